// File: doc/BRIEF.md
# Looping Address Generator with Request Pacing

This block drives the address side of one DMA channel. On a start command it captures a source base, a destination base, a byte count and a mode word. It then presents one byte-wide beat at a time, each with a source and a destination address, and advances whenever the beat is accepted. Either address can run linearly, or it can circle inside a small power-of-two window that begins at its base. The source and destination windows are set independently of each other.

The mode word can hold the beats back in two ways. With external start, the start command only arms the channel, and beats begin once the external start pin is seen high. With external pause, the channel moves a power-of-two quota of bytes for each new rising edge on an asynchronous request pin and then waits again. Its quota counter is emptied at start, so the first bytes also wait for a request edge. When the last byte is accepted the block pulses done. It does not carry any data.

Top module: `dma_addr_pacer`

## Requirements
- R1: While reset is asserted and after its release, `beat_valid` and `done` are low and both address outputs are zero.
- R2: With a side's hold enable clear (source: mode bit 12, destination: mode bit 13), that side's address is base + k on the k-th beat, counting from k = 0.
- R3: With source hold enabled, the source window size is 2^L, where L is mode bits 15:14. Beat k carries source address base + (k mod 2^L). Sizes 1, 2, 4 and 8 are supported.
- R4: Destination hold uses mode bit 13 and window field bits 17:16 in the same way as R3. It is independent of the source setting.
- R5: A transfer presents exactly `byte_total` accepted beats. `done` is high for one cycle, in the cycle after the last beat is accepted. A start with a count of zero gives `done` in the next cycle and no beat.
- R6: While `beat_valid` is high and `beat_ready` is low, `beat_valid` stays high and both addresses hold their values.
- R7: With mode bit 29 set, start arms the channel and no beat is offered. `beat_valid` rises one cycle after `xstart_pin` is sampled high.
- R8: With mode bit 28 set, no beat is offered after start until a request edge. Each edge grants 2^Q bytes, where Q is mode bits 27:24 and values above 10 count as 10. After the grant the channel stops offering beats until the next edge.
- R9: The request pin passes through a two-flop synchronizer. `beat_valid` rises in the third cycle after the pin is first sampled high. Keeping the pin high grants no further bytes.
- R10: A start pulse while a transfer is in progress is ignored. The running transfer keeps its bases and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_base | input | AW | Source base address, captured at start |
| dst_base | input | AW | Destination base address, captured at start |
| byte_total | input | CW | Bytes to move, captured at start |
| mode | input | 32 | Mode word: hold enables, window sizes, quota, pause and start gating |
| start | input | 1 | Start command pulse |
| xstart_pin | input | 1 | External start pin, high level releases an armed channel |
| req_pin | input | 1 | Asynchronous request pin, rising edge grants a quota |
| beat_ready | input | 1 | Beat accepted by the data path |
| src_addr | output | AW | Source byte address of the current beat |
| dst_addr | output | AW | Destination byte address of the current beat |
| beat_valid | output | 1 | A beat is offered |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench builds the block with its default parameters. These are 32-bit addresses, a 16-bit count, a quota ceiling of 2^10, a two-stage synchronizer and hold support present. With these values all four window sizes can be reached on both sides, and a 1030-byte transfer can hit the quota ceiling with a little left over. A clamped quota field of 15 therefore shows a pause after exactly 1024 bytes. A behavioural reference model runs alongside the design and is compared on every clock under both a continuous and a gapped `beat_ready` pattern.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

   localparam int MODE_W       = 32;
   localparam int MB_SRC_HOLD  = 12;
   localparam int MB_DST_HOLD  = 13;
   localparam int MB_SRC_LOG   = 14;
   localparam int MB_DST_LOG   = 16;
   localparam int MB_QLOG      = 24;
   localparam int MB_PAUSE     = 28;
   localparam int MB_XSTART    = 29;
   localparam int SIDES        = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2,
      ST_WAIT  = 2'd3
   } pace_state_e;

   typedef struct packed {
      logic       src_hold;
      logic [1:0] src_log;
      logic       dst_hold;
      logic [1:0] dst_log;
      logic [3:0] qlog;
      logic       pause_en;
      logic       xstart_en;
   } pace_mode_t;

endpackage

// File: rtl/addr_walker.sv
module addr_walker #(
   parameter int AW           = 32,
   parameter bit HOLD_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          hold_en,
   input  logic [1:0]    hold_log,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] off_o,
   output logic [AW-1:0] mask_o,
   output logic          hold_o
);

   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] base_q;
   logic [AW-1:0] off_q;
   logic [AW-1:0] off_next;

   if (AW < 4) begin : g_bad_aw
      $error("addr_walker: AW must be at least 4");
   end

   if (HOLD_SUPPORT) begin : g_hold
      logic          hold_q;
      logic [1:0]    log_q;
      logic [AW-1:0] win_mask;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
            log_q  <= 2'd0;
         end else if (load) begin
            hold_q <= hold_en;
            log_q  <= hold_log;
         end
      end

      assign win_mask = (ONE << log_q) - ONE;
      assign off_next = hold_q ? ((off_q + ONE) & win_mask) : (off_q + ONE);
      assign mask_o   = win_mask;
      assign hold_o   = hold_q;
   end else begin : g_linear
      logic unused_hold;
      assign unused_hold = ^{hold_en, hold_log};
      assign off_next    = off_q + ONE;
      assign mask_o      = '0;
      assign hold_o      = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         off_q  <= '0;
      end else if (load) begin
         base_q <= base;
         off_q  <= '0;
      end else if (step) begin
         off_q  <= off_next;
      end
   end

   assign addr  = base_q + off_q;
   assign off_o = off_q;

endmodule

// File: rtl/quota_gate.sv
module quota_gate #(
   parameter int MAX_QLOG    = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_pin,
   input  logic       clear,
   input  logic       grant,
   input  logic [3:0] qlog,
   input  logic       consume,
   output logic       req_edge,
   output logic       quota_last
);

   localparam int QW = MAX_QLOG + 1;

   logic [SYNC_STAGES:0] sync_q;
   logic [QW-1:0]        quota_q;
   logic [3:0]           eff_log;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("quota_gate: SYNC_STAGES must be at least 2");
   end
   if (MAX_QLOG > 15 || MAX_QLOG < 0) begin : g_bad_qlog
      $error("quota_gate: MAX_QLOG must fit a 4-bit field");
   end

   assign eff_log = (qlog > 4'(MAX_QLOG)) ? 4'(MAX_QLOG) : qlog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-1:0], req_pin};
      end
   end

   assign req_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quota_q <= '0;
      end else if (clear) begin
         quota_q <= '0;
      end else if (grant) begin
         quota_q <= QW'(1) << eff_log;
      end else if (consume && quota_q != '0) begin
         quota_q <= quota_q - QW'(1);
      end
   end

   assign quota_last = (quota_q == QW'(1));

endmodule

// File: rtl/dma_addr_pacer.sv
module dma_addr_pacer
   import pacer_pkg::*;
#(
   parameter int AW           = 32,
   parameter int CW           = 16,
   parameter int MAX_QLOG     = 10,
   parameter int SYNC_STAGES  = 2,
   parameter bit HOLD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     src_base,
   input  logic [AW-1:0]     dst_base,
   input  logic [CW-1:0]     byte_total,
   input  logic [MODE_W-1:0] mode,
   input  logic              start,
   input  logic              xstart_pin,
   input  logic              req_pin,
   input  logic              beat_ready,
   output logic [AW-1:0]     src_addr,
   output logic [AW-1:0]     dst_addr,
   output logic              beat_valid,
   output logic              done
);

   if (CW < 1) begin : g_bad_cw
      $error("dma_addr_pacer: CW must be positive");
   end

   pace_state_e st_q;
   pace_mode_t  mode_in;
   logic [CW-1:0] left_q;
   logic          pause_q;
   logic [3:0]    qlog_q;
   logic          done_q;
   logic          go;
   logic          accept;
   logic          grant;
   logic          req_edge;
   logic          quota_last;
   logic          unused_mode;

   logic [SIDES-1:0][AW-1:0] base_w;
   logic [SIDES-1:0][AW-1:0] addr_w;
   logic [SIDES-1:0][AW-1:0] off_w;
   logic [SIDES-1:0][AW-1:0] mask_w;
   logic [SIDES-1:0]         hold_w;
   logic [SIDES-1:0]         hold_en_w;
   logic [SIDES-1:0][1:0]    hold_log_w;

   assign mode_in.src_hold  = mode[MB_SRC_HOLD];
   assign mode_in.src_log   = mode[MB_SRC_LOG +: 2];
   assign mode_in.dst_hold  = mode[MB_DST_HOLD];
   assign mode_in.dst_log   = mode[MB_DST_LOG +: 2];
   assign mode_in.qlog      = mode[MB_QLOG +: 4];
   assign mode_in.pause_en  = mode[MB_PAUSE];
   assign mode_in.xstart_en = mode[MB_XSTART];
   assign unused_mode = ^{mode[11:0], mode[23:18], mode[31:30]};

   assign go         = start && (st_q == ST_IDLE);
   assign beat_valid = (st_q == ST_RUN);
   assign accept     = beat_valid && beat_ready;
   assign grant      = (st_q == ST_WAIT) && req_edge;
   assign done       = done_q;

   assign base_w[0]     = src_base;
   assign base_w[1]     = dst_base;
   assign hold_en_w[0]  = mode_in.src_hold;
   assign hold_en_w[1]  = mode_in.dst_hold;
   assign hold_log_w[0] = mode_in.src_log;
   assign hold_log_w[1] = mode_in.dst_log;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      addr_walker #(
         .AW           (AW),
         .HOLD_SUPPORT (HOLD_SUPPORT)
      ) u_walker (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (go),
         .base     (base_w[s]),
         .hold_en  (hold_en_w[s]),
         .hold_log (hold_log_w[s]),
         .step     (accept),
         .addr     (addr_w[s]),
         .off_o    (off_w[s]),
         .mask_o   (mask_w[s]),
         .hold_o   (hold_w[s])
      );
   end

   assign src_addr = addr_w[0];
   assign dst_addr = addr_w[1];

   quota_gate #(
      .MAX_QLOG    (MAX_QLOG),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_quota (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_pin    (req_pin),
      .clear      (go),
      .grant      (grant),
      .qlog       (qlog_q),
      .consume    (accept),
      .req_edge   (req_edge),
      .quota_last (quota_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         left_q  <= '0;
         pause_q <= 1'b0;
         qlog_q  <= 4'd0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  left_q  <= byte_total;
                  pause_q <= mode_in.pause_en;
                  qlog_q  <= mode_in.qlog;
                  if (byte_total == '0) begin
                     done_q <= 1'b1;
                  end else if (mode_in.xstart_en) begin
                     st_q <= ST_ARMED;
                  end else if (mode_in.pause_en) begin
                     st_q <= ST_WAIT;
                  end else begin
                     st_q <= ST_RUN;
                  end
               end
            end
            ST_ARMED: begin
               if (xstart_pin) begin
                  st_q <= pause_q ? ST_WAIT : ST_RUN;
               end
            end
            ST_WAIT: begin
               if (req_edge) begin
                  st_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (accept) begin
                  left_q <= left_q - CW'(1);
                  if (left_q == CW'(1)) begin
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else if (pause_q && quota_last) begin
                     st_q <= ST_WAIT;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pacer_chk.sv
module pacer_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          beat_valid,
   input logic          beat_ready,
   input logic          done,
   input logic [AW-1:0] src_addr,
   input logic [AW-1:0] dst_addr,
   input logic [AW-1:0] src_off,
   input logic [AW-1:0] src_wmask,
   input logic          src_hold,
   input logic [AW-1:0] dst_off,
   input logic [AW-1:0] dst_wmask,
   input logic          dst_hold
);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_ready |=> beat_valid && $stable(src_addr) && $stable(dst_addr));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !beat_valid);

   // R2
   src_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && beat_ready && !src_hold |=> src_off == $past(src_off) + AW'(1));

   // R3
   src_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && beat_ready && src_hold && (src_off == src_wmask) |=> src_off == '0);

   // R4
   dst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && beat_ready && dst_hold && (dst_off == dst_wmask) |=> dst_off == '0);

endmodule

bind dma_addr_pacer pacer_chk #(.AW(AW)) u_pacer_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .beat_valid (beat_valid),
   .beat_ready (beat_ready),
   .done       (done),
   .src_addr   (src_addr),
   .dst_addr   (dst_addr),
   .src_off    (off_w[0]),
   .src_wmask  (mask_w[0]),
   .src_hold   (hold_w[0]),
   .dst_off    (off_w[1]),
   .dst_wmask  (mask_w[1]),
   .dst_hold   (hold_w[1])
);

// File: tb/test_dma_addr_pacer.sv
module test_dma_addr_pacer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_base = '0;
   logic [31:0] dst_base = '0;
   logic [15:0] byte_total = '0;
   logic [31:0] mode = '0;
   logic        start = 1'b0;
   logic        xstart_pin = 1'b0;
   logic        req_pin = 1'b0;
   logic        beat_ready = 1'b0;
   logic [31:0] src_addr;
   logic [31:0] dst_addr;
   logic        beat_valid;
   logic        done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit chk_en = 1'b0;
   bit wd_fired = 1'b0;
   int rdy_mode = 0;
   int rdy_cnt = 0;
   string tag = "R1";
   logic [31:0] sq[$];
   logic [31:0] dq[$];

   always #5 clk = ~clk;

   dma_addr_pacer i_dma_addr_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_base   (src_base),
      .dst_base   (dst_base),
      .byte_total (byte_total),
      .mode       (mode),
      .start      (start),
      .xstart_pin (xstart_pin),
      .req_pin    (req_pin),
      .beat_ready (beat_ready),
      .src_addr   (src_addr),
      .dst_addr   (dst_addr),
      .beat_valid (beat_valid),
      .done       (done)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: 0 idle, 1 armed, 2 running, 3 waiting for request
   int          m_state = 0;
   logic [31:0] m_sbase = '0, m_dbase = '0, m_soff = '0, m_doff = '0;
   int          m_left = 0, m_quota = 0, m_ql = 0, m_sl = 0, m_dl = 0;
   bit          m_sh = 0, m_dh = 0, m_pe = 0, m_done = 0;
   bit          m_r1 = 0, m_r2 = 0, m_r3 = 0;

   always @(posedge clk or negedge rst_n) begin : model
      bit redge;
      bit acc;
      if (!rst_n) begin
         m_state = 0; m_sbase = '0; m_dbase = '0; m_soff = '0; m_doff = '0;
         m_left = 0; m_quota = 0; m_done = 0; m_pe = 0;
         m_r1 = 0; m_r2 = 0; m_r3 = 0;
      end else begin
         redge = m_r2 && !m_r3;
         acc = (m_state == 2) && beat_ready;
         m_done = 0;
         case (m_state)
            0: if (start) begin
               m_sbase = src_base; m_dbase = dst_base;
               m_soff = '0; m_doff = '0;
               m_sh = mode[12]; m_dh = mode[13];
               m_sl = int'(mode[15:14]); m_dl = int'(mode[17:16]);
               m_ql = int'(mode[27:24]);
               if (m_ql > 10) m_ql = 10;
               m_pe = mode[28];
               m_quota = 0;
               m_left = int'(byte_total);
               if (m_left == 0) m_done = 1;
               else if (mode[29]) m_state = 1;
               else if (m_pe) m_state = 3;
               else m_state = 2;
            end
            1: if (xstart_pin) m_state = m_pe ? 3 : 2;
            3: if (redge) begin
               m_quota = 1 << m_ql;
               m_state = 2;
            end
            default: if (acc) begin
               m_soff = m_sh ? (m_soff + 1) % (32'd1 << m_sl) : m_soff + 1;
               m_doff = m_dh ? (m_doff + 1) % (32'd1 << m_dl) : m_doff + 1;
               m_left--;
               m_quota--;
               if (m_left == 0) begin
                  m_done = 1;
                  m_state = 0;
               end else if (m_pe && m_quota == 0) begin
                  m_state = 3;
               end
            end
         endcase
         m_r3 = m_r2; m_r2 = m_r1; m_r1 = req_pin;
      end
   end

   // Ready pattern
   always @(negedge clk) begin
      #1;
      rdy_cnt++;
      beat_ready = (rdy_mode == 0) ? 1'b1 : ((rdy_cnt % 3) != 0);
   end

   // Per-cycle comparison and beat monitor
   always @(negedge clk) begin
      #3;
      if (chk_en && !wd_fired) begin
         chk(tag, "beat_valid", beat_valid, (m_state == 2));
         chk(tag, "done", done, m_done);
         chk(tag, "src_addr", src_addr, m_sbase + m_soff);
         chk(tag, "dst_addr", dst_addr, m_dbase + m_doff);
         if (beat_valid && beat_ready) begin
            sq.push_back(src_addr);
            dq.push_back(dst_addr);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !wd_fired) begin
         wd_fired = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] mk(bit sh, int sl, bit dh, int dl, int ql, bit pe, bit xs);
      logic [31:0] m;
      m = '0;
      m[12] = sh; m[13] = dh;
      m[15:14] = sl[1:0]; m[17:16] = dl[1:0];
      m[27:24] = ql[3:0];
      m[28] = pe; m[29] = xs;
      return m;
   endfunction

   task automatic kick(input logic [31:0] sa, input logic [31:0] da, input int n, input logic [31:0] md);
      @(negedge clk); #1;
      sq.delete(); dq.delete();
      src_base = sa; dst_base = da; byte_total = 16'(n); mode = md; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
   endtask

   task automatic wait_done(input string t, input int lim);
      bit seen;
      seen = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk); #4;
         if (done) begin
            seen = 1;
            break;
         end
      end
      chk(t, "done reached", seen, 1'b1);
   endtask

   task automatic verify(input string t, input logic [31:0] sa, input logic [31:0] da, input int n,
                         input bit sh, input int sl, input bit dh, input int dl);
      chk(t, "beat count", sq.size(), n);
      for (int i = 0; i < n && i < sq.size(); i++) begin
         chk(t, "src seq", sq[i], sh ? sa + 32'(i % (1 << sl)) : sa + 32'(i));
         chk(t, "dst seq", dq[i], dh ? da + 32'(i % (1 << dl)) : da + 32'(i));
      end
   endtask

   task automatic xfer(input string t, input logic [31:0] sa, input logic [31:0] da, input int n,
                       input bit sh, input int sl, input bit dh, input int dl, input int rm);
      tag = t;
      rdy_mode = rm;
      kick(sa, da, n, mk(sh, sl, dh, dl, 0, 0, 0));
      wait_done(t, 200);
      verify(t, sa, da, n, sh, sl, dh, dl);
   endtask

   initial begin
      @(posedge clk);
      chk_en = 1'b1;
      // R1: reset state
      @(negedge clk); #4;
      chk("R1", "valid in reset", beat_valid, 1'b0);
      chk("R1", "done in reset", done, 1'b0);
      chk("R1", "src in reset", src_addr, 32'h0);
      chk("R1", "dst in reset", dst_addr, 32'h0);
      @(negedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk); #4;
      chk("R1", "valid after reset", beat_valid, 1'b0);

      // R2 linear, continuous and gapped ready (R6)
      xfer("R2", 32'h1000, 32'h8000, 6, 0, 0, 0, 0, 0);
      xfer("R6", 32'h2000, 32'h9000, 9, 0, 0, 0, 0, 1);

      // R3 source windows 1,2,4,8
      for (int l = 0; l < 4; l++) xfer("R3", 32'h3000 + 32'(l * 16), 32'hA000, 12, 1, l, 0, 0, l % 2);
      // R4 destination windows 1,2,4,8
      for (int l = 0; l < 4; l++) xfer("R4", 32'h4000, 32'hB000 + 32'(l * 16), 12, 0, 0, 1, l, l % 2);
      // R4 independence: both sides hold with different sizes
      xfer("R4", 32'h5003, 32'hC001, 13, 1, 2, 1, 1, 1);

      // R5 zero count
      tag = "R5";
      rdy_mode = 0;
      kick(32'h6000, 32'hD000, 0, 32'h0);
      #3;
      chk("R5", "done for zero count", done, 1'b1);
      chk("R5", "no beat for zero count", sq.size(), 0);
      @(negedge clk); #4;
      chk("R5", "done single cycle", done, 1'b0);

      // R7 external start gating
      tag = "R7";
      kick(32'h7000, 32'hE000, 5, mk(0, 0, 0, 0, 0, 0, 1));
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); #4;
         chk("R7", "armed, no beat", beat_valid, 1'b0);
      end
      @(negedge clk); #1;
      xstart_pin = 1'b1;
      @(negedge clk); #4;
      chk("R7", "valid after pin", beat_valid, 1'b1);
      xstart_pin = 1'b0;
      wait_done("R7", 50);
      verify("R7", 32'h7000, 32'hE000, 5, 0, 0, 0, 0);

      // R8/R9 pause with 4-byte quota
      tag = "R8";
      kick(32'h100, 32'h200, 10, mk(0, 0, 0, 0, 2, 1, 0));
      repeat (6) @(negedge clk);
      #4;
      chk("R8", "no beat before request", sq.size(), 0);
      @(negedge clk); #1;
      req_pin = 1'b1;
      tag = "R9";
      @(negedge clk); #4;
      chk("R9", "sync stage 1", beat_valid, 1'b0);
      @(negedge clk); #4;
      chk("R9", "sync stage 2", beat_valid, 1'b0);
      @(negedge clk); #4;
      chk("R9", "valid after sync", beat_valid, 1'b1);
      #0;
      req_pin = 1'b0;
      repeat (12) @(negedge clk);
      #4;
      chk("R8", "first quota", sq.size(), 4);
      chk("R8", "paused after quota", beat_valid, 1'b0);
      @(negedge clk); #1;
      req_pin = 1'b1;
      repeat (25) @(negedge clk);
      #4;
      chk("R9", "held pin grants once", sq.size(), 8);
      @(negedge clk); #1;
      req_pin = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      req_pin = 1'b1;
      wait_done("R8", 30);
      req_pin = 1'b0;
      verify("R8", 32'h100, 32'h200, 10, 0, 0, 0, 0);

      // R8 quota field above ceiling clamps to 1024
      tag = "R8";
      kick(32'h10000, 32'h20000, 1030, mk(0, 0, 0, 0, 15, 1, 0));
      @(negedge clk); #1;
      req_pin = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      req_pin = 1'b0;
      repeat (1100) @(negedge clk);
      #4;
      chk("R8", "clamped quota", sq.size(), 1024);
      @(negedge clk); #1;
      req_pin = 1'b1;
      wait_done("R8", 40);
      req_pin = 1'b0;
      verify("R8", 32'h10000, 32'h20000, 1030, 0, 0, 0, 0);

      // R10 start while busy is ignored
      tag = "R10";
      rdy_mode = 1;
      kick(32'h3300, 32'h4400, 8, mk(1, 1, 0, 0, 0, 0, 0));
      repeat (2) @(negedge clk);
      #1;
      src_base = 32'hFFFF0000; dst_base = 32'hEEEE0000; byte_total = 16'd2; mode = 32'h0;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      wait_done("R10", 60);
      verify("R10", 32'h3300, 32'h4400, 8, 1, 1, 0, 0);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule